// File: doc/BRIEF.md
# Receive Packet FIFO with Early-Drop Rewind

This block is the buffer between a receive protocol engine, which writes packet words, and a DMA-style reader, which drains them. Every stored entry is a data word with three tag bits: start of packet, end of packet and status. The reader can rebuild packet boundaries from these tags. The opening words of each packet are kept hidden from the reader until a threshold of words has been written. Until then the writer can still abandon the packet: the write pointer goes back to the packet's first entry and the words already stored are discarded.

Once a packet is committed it can no longer be dropped. From then on, an error only sets a flag in the packet's status word. When status append is enabled, a status entry follows the last data word. It holds the number of data words stored, an error bit and a truncation bit. A read from an empty FIFO sets a sticky underflow flag. A write into a full FIFO sets a sticky overflow flag. Both flags stay set until a clear is requested.

Top module: `rx_rewind_fifo`

## Requirements
- R1: While a packet has fewer stored words than the threshold and has not ended, none of its entries is visible: `rd_level` does not count them and `rd_avail` stays low for them.
- R2: In the write that brings the packet's stored-word count up to the threshold, all of its stored words become visible together, and `rd_level` jumps by that count one cycle later. After that, each further accepted word is visible in the cycle after its write.
- R3: An asserted `wr_fail` before commit rewinds the write pointer to the packet's first entry. No word of that packet ever reaches the reader, and the next packet is read from the reused slots.
- R4: An asserted `wr_fail` after commit does not drop the packet. All of its words are delivered, and its status entry has the error bit set.
- R5: A packet that ends before reaching the threshold, with no failure, is committed at its end-of-packet word.
- R6: With `cfg_stat_en` high at end of packet, one extra entry is written in the following cycle with `rd_stat`=1, sop=eop=0. Its data holds the stored data-word count in bits [LEN_W-1:0], the error bit at LEN_W and the truncation bit (words lost to overflow) at LEN_W+1, with the other bits zero. With `cfg_stat_en` low, no extra entry is written.
- R7: `rd_en` while nothing is visible leaves the read pointer unchanged and sets `udf_flag`.
- R8: A write while 2^ADDR_W entries are held is discarded and sets `ovf_flag`. If the packet was not yet committed, the whole packet is rewound and dropped. If it was committed, the words already stored remain, the later words are lost and the truncation bit is set.
- R9: `ovf_flag` and `udf_flag` are zero after reset and return to zero only in the cycle after `flag_clr`. A new event in the same cycle as `flag_clr` keeps its flag set.
- R10: The threshold is taken from `cfg_thresh` at the packet's start word. Changing `cfg_thresh` later has no effect on that packet.
- R11: The reader sees each packet's words in write order. The first word has `rd_sop`=1 and the last data word has `rd_eop`=1.
- R12: A word offered in the cycle reserved for a status entry is discarded and sets `ovf_flag`. The status entry is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_thresh | input | THR_W | Visibility threshold in words, sampled at start of packet |
| cfg_stat_en | input | 1 | Append a status entry at end of packet |
| flag_clr | input | 1 | Clear the sticky overflow and underflow flags |
| wr_valid | input | 1 | Writer offers a word this cycle |
| wr_sop | input | 1 | Offered word starts a packet |
| wr_eop | input | 1 | Offered word ends the packet |
| wr_fail | input | 1 | Writer reports an error in the current packet |
| wr_data | input | DATA_W | Offered word |
| rd_en | input | 1 | Reader pops the head entry |
| rd_avail | output | 1 | At least one entry is visible |
| rd_level | output | ADDR_W+1 | Number of visible entries |
| rd_data | output | DATA_W | Head entry data |
| rd_sop | output | 1 | Head entry starts a packet |
| rd_eop | output | 1 | Head entry is the last data word |
| rd_stat | output | 1 | Head entry is a status word |
| ovf_flag | output | 1 | Sticky overflow |
| udf_flag | output | 1 | Sticky underflow |

## Verification
The bench builds the block with an 8-entry store, 16-bit words, an 8-bit length field and a 4-bit threshold. Because the threshold can go up to 15, above the depth, a packet can fill the store before it commits, which exercises the rewind-on-overflow path. The small depth also lets a committed packet hit full within a few words, so both the lost-word case and the lost-status case occur. Thresholds of 1 and 2 exercise commit on the start word and commit mid-packet.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_HOLD = 2'd1,
    WS_PASS = 2'd2,
    WS_DROP = 2'd3
  } wstate_e;

  localparam int TAG_W = 3;

endpackage

// File: rtl/rxf_storage.sv
module rxf_storage #(
  parameter int ENT_W  = 35,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [ENT_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [ENT_W-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxf_write_ctrl.sv
module rxf_write_ctrl
  import rxf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int LEN_W  = 16,
  parameter int THR_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  logic                     wr_sop,
  input  logic                     wr_eop,
  input  logic                     wr_fail,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [THR_W-1:0]         cfg_thresh,
  input  logic                     cfg_stat_en,
  input  logic [ADDR_W:0]          rd_ptr,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_waddr,
  output logic [DATA_W+TAG_W-1:0]  mem_wdata,
  output logic [ADDR_W:0]          wr_ptr_o,
  output logic [ADDR_W:0]          wr_vis_o,
  output logic [ADDR_W:0]          pkt_start_o,
  output logic                     in_hold_o,
  output logic                     ev_rewind_o,
  output logic                     ev_commit_o,
  output logic                     ev_ovf_o
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int ENT_W = DATA_W + TAG_W;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

  function automatic logic [PTR_W-1:0] span(input logic [PTR_W-1:0] a,
                                            input logic [PTR_W-1:0] b);
    return a - b;
  endfunction

  function automatic logic reach(input logic [LEN_W-1:0] c,
                                 input logic [THR_W-1:0] t);
    return 32'(c) >= 32'(t);
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(input logic [LEN_W-1:0] len,
                                                    input logic err,
                                                    input logic trunc);
    logic [DATA_W-1:0] r;
    r = '0;
    r[LEN_W-1:0] = len;
    r[LEN_W]     = err;
    r[LEN_W+1]   = trunc;
    return r;
  endfunction

  function automatic logic [ENT_W-1:0] entry(input logic stat, input logic eop,
                                             input logic sop,
                                             input logic [DATA_W-1:0] d);
    return {stat, eop, sop, d};
  endfunction

  wstate_e          state_q, state_n;
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_n, wr_vis_q, wr_vis_n, start_q, start_n;
  logic [LEN_W-1:0] cnt_q, cnt_n, slen_q, slen_n;
  logic [THR_W-1:0] thr_q, thr_n;
  logic             err_q, err_n, trunc_q, trunc_n;
  logic             spend_q, spend_n, serr_q, serr_n, strunc_q, strunc_n;

  logic [PTR_W-1:0] base;
  logic             full_live, full_base;
  logic [LEN_W-1:0] cnt_inc;
  logic             err_v, commit;

  assign base      = (state_q == WS_HOLD) ? start_q : wr_ptr_q;
  assign full_live = span(wr_ptr_q, rd_ptr) == DEPTH_P;
  assign full_base = span(base, rd_ptr) == DEPTH_P;
  assign cnt_inc   = cnt_q + LEN_W'(1);
  assign err_v     = err_q | wr_fail;

  always_comb begin
    state_n   = state_q;
    wr_ptr_n  = wr_ptr_q;
    wr_vis_n  = wr_vis_q;
    start_n   = start_q;
    cnt_n     = cnt_q;
    thr_n     = thr_q;
    err_n     = err_q;
    trunc_n   = trunc_q;
    spend_n   = spend_q;
    slen_n    = slen_q;
    serr_n    = serr_q;
    strunc_n  = strunc_q;
    mem_we    = 1'b0;
    mem_waddr = wr_ptr_q[ADDR_W-1:0];
    mem_wdata = entry(1'b0, wr_eop, wr_sop, wr_data);
    ev_rewind_o = 1'b0;
    ev_ovf_o    = 1'b0;
    commit      = 1'b0;

    if (spend_q) begin
      spend_n = 1'b0;
      if (full_live) begin
        ev_ovf_o = 1'b1;
      end else begin
        mem_we    = 1'b1;
        mem_wdata = entry(1'b1, 1'b0, 1'b0, pack_status(slen_q, serr_q, strunc_q));
        wr_ptr_n  = wr_ptr_q + PTR_W'(1);
        wr_vis_n  = wr_ptr_q + PTR_W'(1);
      end
      if (wr_valid) ev_ovf_o = 1'b1;
    end else if (wr_valid && wr_sop) begin
      ev_rewind_o = (state_q == WS_HOLD);
      thr_n    = cfg_thresh;
      err_n    = 1'b0;
      trunc_n  = 1'b0;
      start_n  = base;
      wr_ptr_n = base;
      if (wr_fail || full_base) begin
        ev_ovf_o = full_base;
        cnt_n    = '0;
        state_n  = wr_eop ? WS_IDLE : WS_DROP;
      end else begin
        mem_we    = 1'b1;
        mem_waddr = base[ADDR_W-1:0];
        wr_ptr_n  = base + PTR_W'(1);
        cnt_n     = LEN_W'(1);
        commit    = wr_eop || reach(LEN_W'(1), cfg_thresh);
        if (commit) wr_vis_n = base + PTR_W'(1);
        if (wr_eop) begin
          state_n  = WS_IDLE;
          spend_n  = cfg_stat_en;
          slen_n   = LEN_W'(1);
          serr_n   = 1'b0;
          strunc_n = 1'b0;
        end else begin
          state_n = commit ? WS_PASS : WS_HOLD;
        end
      end
    end else begin
      unique case (state_q)
        WS_HOLD: begin
          if (wr_fail) begin
            ev_rewind_o = 1'b1;
            wr_ptr_n    = start_q;
            state_n     = (wr_valid && wr_eop) ? WS_IDLE : WS_DROP;
          end else if (wr_valid) begin
            if (full_live) begin
              ev_rewind_o = 1'b1;
              ev_ovf_o    = 1'b1;
              wr_ptr_n    = start_q;
              state_n     = wr_eop ? WS_IDLE : WS_DROP;
            end else begin
              mem_we   = 1'b1;
              wr_ptr_n = wr_ptr_q + PTR_W'(1);
              cnt_n    = cnt_inc;
              commit   = wr_eop || reach(cnt_inc, thr_q);
              if (commit) wr_vis_n = wr_ptr_q + PTR_W'(1);
              if (wr_eop) begin
                state_n  = WS_IDLE;
                spend_n  = cfg_stat_en;
                slen_n   = cnt_inc;
                serr_n   = 1'b0;
                strunc_n = 1'b0;
              end else if (commit) begin
                state_n = WS_PASS;
              end
            end
          end
        end
        WS_PASS: begin
          err_n = err_v;
          if (wr_valid) begin
            if (full_live) begin
              ev_ovf_o = 1'b1;
              trunc_n  = 1'b1;
              if (wr_eop) begin
                state_n  = WS_IDLE;
                spend_n  = cfg_stat_en;
                slen_n   = cnt_q;
                serr_n   = err_v;
                strunc_n = 1'b1;
              end
            end else begin
              mem_we   = 1'b1;
              wr_ptr_n = wr_ptr_q + PTR_W'(1);
              wr_vis_n = wr_ptr_q + PTR_W'(1);
              cnt_n    = cnt_inc;
              commit   = 1'b1;
              if (wr_eop) begin
                state_n  = WS_IDLE;
                spend_n  = cfg_stat_en;
                slen_n   = cnt_inc;
                serr_n   = err_v;
                strunc_n = trunc_q;
              end
            end
          end
        end
        WS_DROP: begin
          if (wr_valid && wr_eop) state_n = WS_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= WS_IDLE;
      wr_ptr_q <= '0;
      wr_vis_q <= '0;
      start_q  <= '0;
      cnt_q    <= '0;
      thr_q    <= '0;
      err_q    <= 1'b0;
      trunc_q  <= 1'b0;
      spend_q  <= 1'b0;
      slen_q   <= '0;
      serr_q   <= 1'b0;
      strunc_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      wr_ptr_q <= wr_ptr_n;
      wr_vis_q <= wr_vis_n;
      start_q  <= start_n;
      cnt_q    <= cnt_n;
      thr_q    <= thr_n;
      err_q    <= err_n;
      trunc_q  <= trunc_n;
      spend_q  <= spend_n;
      slen_q   <= slen_n;
      serr_q   <= serr_n;
      strunc_q <= strunc_n;
    end
  end

  assign wr_ptr_o    = wr_ptr_q;
  assign wr_vis_o    = wr_vis_q;
  assign pkt_start_o = start_q;
  assign in_hold_o   = (state_q == WS_HOLD);
  assign ev_commit_o = commit;
endmodule

// File: rtl/rxf_read_ctrl.sv
module rxf_read_ctrl #(
  parameter int ADDR_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic [ADDR_W:0] wr_vis,
  output logic [ADDR_W:0] rd_ptr_o,
  output logic            rd_avail,
  output logic [ADDR_W:0] rd_level,
  output logic            ev_underflow
);
  localparam int PTR_W = ADDR_W + 1;

  function automatic logic [PTR_W-1:0] visible(input logic [PTR_W-1:0] vis,
                                               input logic [PTR_W-1:0] rp);
    return vis - rp;
  endfunction

  logic [PTR_W-1:0] rd_ptr_q;
  logic             pop;

  assign rd_level     = visible(wr_vis, rd_ptr_q);
  assign rd_avail     = rd_level != '0;
  assign pop          = rd_en && rd_avail;
  assign ev_underflow = rd_en && !rd_avail;

  always_ff @(posedge clk) begin
    if (!rst_n)   rd_ptr_q <= '0;
    else if (pop) rd_ptr_q <= rd_ptr_q + PTR_W'(1);
  end

  assign rd_ptr_o = rd_ptr_q;
endmodule

// File: rtl/rxf_sticky_flags.sv
module rxf_sticky_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_clr,
  input  logic set_ovf,
  input  logic set_udf,
  output logic ovf,
  output logic udf
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      udf <= 1'b0;
    end else begin
      ovf <= set_ovf | (ovf & ~flag_clr);
      udf <= set_udf | (udf & ~flag_clr);
    end
  end
endmodule

// File: rtl/rx_rewind_fifo.sv
module rx_rewind_fifo
  import rxf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int LEN_W  = 16,
  parameter int THR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [THR_W-1:0]  cfg_thresh,
  input  logic              cfg_stat_en,
  input  logic              flag_clr,
  input  logic              wr_valid,
  input  logic              wr_sop,
  input  logic              wr_eop,
  input  logic              wr_fail,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic              rd_avail,
  output logic [ADDR_W:0]   rd_level,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_sop,
  output logic              rd_eop,
  output logic              rd_stat,
  output logic              ovf_flag,
  output logic              udf_flag
);
  localparam int ENT_W = DATA_W + TAG_W;

  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [ENT_W-1:0]  mem_wdata, mem_rdata;
  logic [ADDR_W:0]   wr_ptr_w, wr_vis_w, pkt_start_w, rd_ptr_w;
  logic              in_hold_w, ev_rewind_w, ev_commit_w, ev_ovf_w, ev_udf_w;

  rxf_write_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .THR_W(THR_W)
  ) wctl_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_fail(wr_fail),
    .wr_data(wr_data), .cfg_thresh(cfg_thresh), .cfg_stat_en(cfg_stat_en),
    .rd_ptr(rd_ptr_w),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .wr_ptr_o(wr_ptr_w), .wr_vis_o(wr_vis_w), .pkt_start_o(pkt_start_w),
    .in_hold_o(in_hold_w), .ev_rewind_o(ev_rewind_w),
    .ev_commit_o(ev_commit_w), .ev_ovf_o(ev_ovf_w)
  );

  rxf_storage #(.ENT_W(ENT_W), .ADDR_W(ADDR_W)) mem_i (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_ptr_w[ADDR_W-1:0]), .rdata(mem_rdata)
  );

  rxf_read_ctrl #(.ADDR_W(ADDR_W)) rctl_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_vis(wr_vis_w),
    .rd_ptr_o(rd_ptr_w), .rd_avail(rd_avail), .rd_level(rd_level),
    .ev_underflow(ev_udf_w)
  );

  rxf_sticky_flags flags_i (
    .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr),
    .set_ovf(ev_ovf_w), .set_udf(ev_udf_w),
    .ovf(ovf_flag), .udf(udf_flag)
  );

  assign rd_data = mem_rdata[DATA_W-1:0];
  assign rd_sop  = mem_rdata[DATA_W];
  assign rd_eop  = mem_rdata[DATA_W+1];
  assign rd_stat = mem_rdata[DATA_W+2];
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int ADDR_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_en,
  input logic            rd_avail,
  input logic            flag_clr,
  input logic            ovf_flag,
  input logic            udf_flag,
  input logic [ADDR_W:0] wr_ptr,
  input logic [ADDR_W:0] wr_vis,
  input logic [ADDR_W:0] rd_ptr,
  input logic [ADDR_W:0] pkt_start,
  input logic            in_hold,
  input logic            ev_rewind,
  input logic            ev_commit,
  input logic            ev_ovf
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

  logic [PTR_W-1:0] held, shown;
  assign held  = wr_ptr - rd_ptr;
  assign shown = wr_vis - rd_ptr;

  assert_hold_hidden_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold |-> wr_vis == pkt_start);

  assert_visible_within_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shown <= held);

  assert_rewind_hides_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rewind && !ev_commit |=> $stable(wr_vis));

  assert_underflow_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rd_avail |=> $stable(rd_ptr));

  assert_underflow_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rd_avail |=> udf_flag);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    held <= DEPTH_P);

  assert_ovf_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> ovf_flag);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !flag_clr |=> ovf_flag);

  assert_udf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    udf_flag && !flag_clr |=> udf_flag);
endmodule

bind rx_rewind_fifo rxf_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_avail(rd_avail),
  .flag_clr(flag_clr), .ovf_flag(ovf_flag), .udf_flag(udf_flag),
  .wr_ptr(wr_ptr_w), .wr_vis(wr_vis_w), .rd_ptr(rd_ptr_w),
  .pkt_start(pkt_start_w), .in_hold(in_hold_w), .ev_rewind(ev_rewind_w),
  .ev_commit(ev_commit_w), .ev_ovf(ev_ovf_w)
);

// File: tb/rx_rewind_fifo_tb_top.sv
module rx_rewind_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int LEN_W  = 8;
  localparam int THR_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [THR_W-1:0]  cfg_thresh = '0;
  logic              cfg_stat_en = 1'b0;
  logic              flag_clr = 1'b0;
  logic              wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0, wr_fail = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_en = 1'b0;
  logic              rd_avail, rd_sop, rd_eop, rd_stat, ovf_flag, udf_flag;
  logic [ADDR_W:0]   rd_level;
  logic [DATA_W-1:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_rewind_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .THR_W(THR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_thresh(cfg_thresh), .cfg_stat_en(cfg_stat_en),
    .flag_clr(flag_clr), .wr_valid(wr_valid), .wr_sop(wr_sop), .wr_eop(wr_eop),
    .wr_fail(wr_fail), .wr_data(wr_data), .rd_en(rd_en), .rd_avail(rd_avail),
    .rd_level(rd_level), .rd_data(rd_data), .rd_sop(rd_sop), .rd_eop(rd_eop),
    .rd_stat(rd_stat), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  function automatic logic [DATA_W-1:0] status_word(int len, bit err, bit trunc);
    logic [DATA_W-1:0] w;
    w = '0;
    w[LEN_W-1:0] = LEN_W'(len);
    w[LEN_W] = err;
    w[LEN_W+1] = trunc;
    return w;
  endfunction

  task automatic check(string req, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic beat(bit sop, bit eop, bit fail, logic [DATA_W-1:0] d);
    wr_valid = 1'b1; wr_sop = sop; wr_eop = eop; wr_fail = fail; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0; wr_fail = 1'b0;
  endtask

  task automatic fail_only();
    wr_fail = 1'b1;
    @(negedge clk);
    wr_fail = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop_check(string req, logic [DATA_W-1:0] d, bit sop, bit eop, bit st);
    check(req, "rd_avail", int'(rd_avail), 1);
    check(req, "rd_data", int'(rd_data), int'(d));
    check(req, "rd_sop", int'(rd_sop), int'(sop));
    check(req, "rd_eop", int'(rd_eop), int'(eop));
    check(req, "rd_stat", int'(rd_stat), int'(st));
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R9", "reset ovf", int'(ovf_flag), 0);
    check("R9", "reset udf", int'(udf_flag), 0);
    check("R1", "reset level", int'(rd_level), 0);
  endtask

  task automatic t_hold_commit();
    cfg_thresh = 4; cfg_stat_en = 1'b0;
    beat(1, 0, 0, 16'h1001);
    check("R1", "level after 1", int'(rd_level), 0);
    beat(0, 0, 0, 16'h1002);
    beat(0, 0, 0, 16'h1003);
    check("R1", "level after 3", int'(rd_level), 0);
    beat(0, 0, 0, 16'h1004);
    check("R2", "level at threshold", int'(rd_level), 4);
    beat(0, 1, 0, 16'h1005);
    check("R2", "level after eop", int'(rd_level), 5);
    pop_check("R11", 16'h1001, 1, 0, 0);
    for (int i = 2; i <= 4; i++) pop_check("R11", DATA_W'(16'h1000 + i), 0, 0, 0);
    pop_check("R6", 16'h1005, 0, 1, 0);
    check("R6", "no status when disabled", int'(rd_level), 0);
  endtask

  task automatic t_short();
    cfg_thresh = 4;
    beat(1, 0, 0, 16'h2001);
    beat(0, 1, 0, 16'h2002);
    check("R5", "short packet level", int'(rd_level), 2);
    pop_check("R5", 16'h2001, 1, 0, 0);
    pop_check("R5", 16'h2002, 0, 1, 0);
  endtask

  task automatic t_drop_fail();
    cfg_thresh = 4;
    beat(1, 0, 0, 16'h3001);
    beat(0, 0, 0, 16'h3002);
    fail_only();
    check("R3", "dropped level", int'(rd_level), 0);
    beat(0, 0, 0, 16'h3003);
    beat(0, 1, 0, 16'h3004);
    check("R3", "tail of dropped ignored", int'(rd_level), 0);
    beat(1, 1, 0, 16'h3005);
    check("R3", "next packet level", int'(rd_level), 1);
    pop_check("R3", 16'h3005, 1, 1, 0);
  endtask

  task automatic t_late_err();
    cfg_thresh = 2; cfg_stat_en = 1'b1;
    beat(1, 0, 0, 16'h4001);
    beat(0, 0, 0, 16'h4002);
    beat(0, 0, 1, 16'h4003);
    beat(0, 1, 0, 16'h4004);
    idle(1);
    check("R4", "late error level", int'(rd_level), 5);
    pop_check("R4", 16'h4001, 1, 0, 0);
    pop_check("R4", 16'h4002, 0, 0, 0);
    pop_check("R4", 16'h4003, 0, 0, 0);
    pop_check("R4", 16'h4004, 0, 1, 0);
    pop_check("R4", status_word(4, 1, 0), 0, 0, 1);
    cfg_stat_en = 1'b0;
  endtask

  task automatic t_stat_clean();
    cfg_thresh = 1; cfg_stat_en = 1'b1;
    beat(1, 0, 0, 16'h5001);
    check("R2", "threshold one", int'(rd_level), 1);
    beat(0, 1, 0, 16'h5002);
    idle(1);
    check("R6", "level with status", int'(rd_level), 3);
    pop_check("R6", 16'h5001, 1, 0, 0);
    pop_check("R6", 16'h5002, 0, 1, 0);
    pop_check("R6", status_word(2, 0, 0), 0, 0, 1);
    cfg_stat_en = 1'b0;
  endtask

  task automatic t_thr_sample();
    cfg_thresh = 2;
    beat(1, 0, 0, 16'h6001);
    cfg_thresh = 8;
    beat(0, 0, 0, 16'h6002);
    check("R10", "threshold latched at sop", int'(rd_level), 2);
    beat(0, 1, 0, 16'h6003);
    for (int i = 1; i <= 3; i++)
      pop_check("R10", DATA_W'(16'h6000 + i), i == 1, i == 3, 0);
  endtask

  task automatic t_underflow();
    clear_flags();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R7", "udf set", int'(udf_flag), 1);
    check("R7", "level unchanged", int'(rd_level), 0);
    cfg_thresh = 1;
    beat(1, 1, 0, 16'h7001);
    pop_check("R7", 16'h7001, 1, 1, 0);
    check("R7", "empty after", int'(rd_level), 0);
  endtask

  task automatic t_flag_clear();
    idle(3);
    check("R9", "udf still set", int'(udf_flag), 1);
    clear_flags();
    check("R9", "udf cleared", int'(udf_flag), 0);
    check("R9", "ovf clear", int'(ovf_flag), 0);
  endtask

  task automatic t_ovf_pre();
    clear_flags();
    cfg_thresh = 15; cfg_stat_en = 1'b0;
    beat(1, 0, 0, 16'h8001);
    for (int i = 2; i <= 9; i++) beat(0, 0, 0, DATA_W'(16'h8000 + i));
    check("R8", "pre-commit overflow flag", int'(ovf_flag), 1);
    check("R8", "pre-commit dropped level", int'(rd_level), 0);
    cfg_thresh = 1;
    beat(1, 1, 0, 16'h8100);
    check("R8", "after drop level", int'(rd_level), 1);
    pop_check("R8", 16'h8100, 1, 1, 0);
  endtask

  task automatic t_ovf_post();
    clear_flags();
    cfg_thresh = 1; cfg_stat_en = 1'b1;
    beat(1, 0, 0, 16'h9001);
    for (int i = 2; i <= 8; i++) beat(0, 0, 0, DATA_W'(16'h9000 + i));
    check("R8", "full level", int'(rd_level), 8);
    check("R8", "no ovf yet", int'(ovf_flag), 0);
    beat(0, 1, 0, 16'h9009);
    idle(1);
    check("R8", "post-commit ovf flag", int'(ovf_flag), 1);
    check("R8", "level stays full", int'(rd_level), 8);
    pop_check("R8", 16'h9001, 1, 0, 0);
    for (int i = 2; i <= 8; i++) pop_check("R8", DATA_W'(16'h9000 + i), 0, 0, 0);
    check("R8", "lost word absent", int'(rd_level), 0);
    cfg_stat_en = 1'b0;
  endtask

  task automatic t_collide();
    clear_flags();
    cfg_thresh = 1; cfg_stat_en = 1'b1;
    beat(1, 1, 0, 16'hA001);
    beat(1, 1, 0, 16'hA002);
    check("R12", "collision ovf", int'(ovf_flag), 1);
    check("R12", "collision level", int'(rd_level), 2);
    pop_check("R12", 16'hA001, 1, 1, 0);
    pop_check("R12", status_word(1, 0, 0), 0, 0, 1);
    check("R12", "collided word absent", int'(rd_level), 0);
    cfg_stat_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hold_commit();
    t_short();
    t_drop_fail();
    t_late_err();
    t_stat_clean();
    t_thr_sample();
    t_underflow();
    t_flag_clear();
    t_ovf_pre();
    t_ovf_post();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule